// File: doc/BRIEF.md
# Type B Reader Command Frame Serializer

This block turns a reader command held in a byte buffer into the serial bit stream that a proximity-card reader hands to its modulator during a Type B exchange. A command of up to `MAX_BYTES` bytes, with its CRC already appended, is fetched one byte at a time through a read port. The block then emits the whole frame one bit per handshake. The frame is built in this order: a run of logic-1 bits that lets the card settle on a reference level, a start-of-frame marker of logic-0 bits, each byte framed as an asynchronous character, an end-of-frame marker, and a trailing run of logic-1 bits. That last run keeps the final character in the modulator's path until it has fully left, before the receive path is switched on.

The caller pulses `start_i` with the byte count on `len_i`. The byte count is captured when the pulse is taken. While a frame is under way, `rd_addr_o` points at the byte being sent, and the buffer must return that byte on `rd_data_i` in the same cycle. The bit stream follows valid/ready rules. `bit_valid_o` is high for the whole frame. A bit is consumed only in a cycle where `bit_valid_o` and `bit_ready_i` are both high. While `bit_ready_i` is low, the block holds `bit_o` and all of its state, so the modulator can stall for any number of cycles without losing or repeating a bit. `busy_o` and `done_o` are plain status pins.

Top module: `frame_bit_serializer`

## Requirements
- R1: After reset, `busy_o`, `bit_valid_o` and `done_o` are all 0.
- R2: Every frame opens with `PRE_BITS` (default 40) logic-1 bits, followed by `SOF_BITS` (default 10) logic-0 bits.
- R3: Each byte is sent as one logic-0 start bit, then its 8 data bits with bit 0 first, then one logic-1 stop bit, then `EGT_BITS` (default 1) logic-1 guard bits. Bytes are read at `rd_addr_o` = 0, 1, … up to length−1, in that order.
- R4: After the last byte, the frame ends with one logic-1 bit, `EOF_ZERO_BITS` (default 10) logic-0 bits and `EOF_ONE_BITS` (default 8) logic-1 bits. It is then followed by `GUARD_BITS` (default 24) logic-1 bits.
- R5: A length of zero gives the preamble, start-of-frame, end-of-frame and trailing guard only. With the defaults, that is 93 bits.
- R6: One bit is consumed per cycle in which `bit_valid_o` and `bit_ready_i` are both high. While `bit_ready_i` is low, `bit_valid_o` stays high and `bit_o` stays unchanged. No bit is ever dropped or repeated.
- R7: `busy_o` rises in the cycle after an accepted start. It falls in the cycle after the last trailing guard bit is consumed. In that same cycle, `done_o` is high for exactly one cycle.
- R8: A start pulse while `busy_o` is high is ignored, together with its `len_i`. The frame in progress continues unchanged.
- R9: A `len_i` above `MAX_BYTES` is treated as `MAX_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| len_i | input | LEN_W (5) | Command length in bytes, CRC included |
| rd_addr_o | output | ADDR_W (4) | Byte buffer read address |
| rd_data_i | input | 8 | Byte at `rd_addr_o`, same cycle |
| bit_o | output | 1 | Serial bit toward the modulator |
| bit_valid_o | output | 1 | `bit_o` holds a frame bit |
| bit_ready_i | input | 1 | Modulator takes the bit this cycle |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
The bench sweeps every length from zero to the buffer size. Each length is run under four readiness patterns: always ready, a regular one-in-three stall, an irregular stall pattern and long stall bursts. Comparing the bit streams across these patterns separates a correct frame layout from the handshake's hold-and-advance behaviour. The buffer bytes include all-zero, all-one and single-bit values, so a wrong data bit order or a misplaced start or stop bit shows up as a specific bit mismatch. Two further runs check the remaining cases. One uses an oversize length, which must produce a frame of the full buffer size. The other sends a start pulse with a different length in the middle of a frame, which must leave that frame unchanged.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SOF,
    PH_CHR,
    PH_EOF,
    PH_GUARD
  } fbs_phase_e;
endpackage

// File: rtl/fbs_seq.sv
module fbs_seq
  import fbs_pkg::*;
#(
  parameter int MAX_BYTES  = 16,
  parameter int PRE_BITS   = 40,
  parameter int SOF_BITS   = 10,
  parameter int CHAR_BITS  = 11,
  parameter int EOF_BITS   = 19,
  parameter int GUARD_BITS = 24,
  parameter int LEN_W      = 5,
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              adv_i,
  output fbs_phase_e        phase_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              done_o
);

  fbs_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] idx_q;
  logic [LEN_W-1:0]  len_q;
  logic              done_q;
  logic [CNT_W-1:0]  last_cnt;
  logic [LEN_W-1:0]  len_clamped;
  logic              last_byte;

  always_comb begin
    case (phase_q)
      PH_PRE:   last_cnt = CNT_W'(PRE_BITS - 1);
      PH_SOF:   last_cnt = CNT_W'(SOF_BITS - 1);
      PH_CHR:   last_cnt = CNT_W'(CHAR_BITS - 1);
      PH_EOF:   last_cnt = CNT_W'(EOF_BITS - 1);
      PH_GUARD: last_cnt = CNT_W'(GUARD_BITS - 1);
      default:  last_cnt = '0;
    endcase
  end

  assign len_clamped = (len_i > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : len_i;
  assign last_byte   = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          len_q   <= len_clamped;
          phase_q <= PH_PRE;
          cnt_q   <= '0;
          idx_q   <= '0;
        end
      end else if (adv_i) begin
        if (cnt_q == last_cnt) begin
          cnt_q <= '0;
          case (phase_q)
            PH_PRE: phase_q <= PH_SOF;
            PH_SOF: phase_q <= (len_q == '0) ? PH_EOF : PH_CHR;
            PH_CHR: begin
              if (last_byte) phase_q <= PH_EOF;
              else           idx_q   <= idx_q + 1'b1;
            end
            PH_EOF: phase_q <= PH_GUARD;
            PH_GUARD: begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !adv_i) |=> ($stable(cnt_q) && $stable(idx_q) && phase_q == $past(phase_q))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_IDLE)); // R7
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(len_q)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CHR) |-> (LEN_W'(idx_q) < len_q)); // R3
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (len_q <= LEN_W'(MAX_BYTES))); // R9

endmodule

// File: rtl/fbs_bit_gen.sv
module fbs_bit_gen
  import fbs_pkg::*;
#(
  parameter int EOF_ZERO_BITS = 10,
  parameter int CNT_W         = 6
) (
  input  fbs_phase_e       phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [7:0]       data_i,
  output logic             bit_o
);

  logic [2:0] data_sel;

  assign data_sel = 3'(cnt_i - 1'b1);

  always_comb begin
    case (phase_i)
      PH_SOF: bit_o = 1'b0;
      PH_CHR: begin
        if (cnt_i == '0)                 bit_o = 1'b0;
        else if (cnt_i <= CNT_W'(8))     bit_o = data_i[data_sel];
        else                             bit_o = 1'b1;
      end
      PH_EOF: begin
        if (cnt_i == '0)                       bit_o = 1'b1;
        else if (cnt_i <= CNT_W'(EOF_ZERO_BITS)) bit_o = 1'b0;
        else                                   bit_o = 1'b1;
      end
      default: bit_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/frame_bit_serializer.sv
module frame_bit_serializer
  import fbs_pkg::*;
#(
  parameter int MAX_BYTES     = 16,
  parameter int EGT_BITS      = 1,
  parameter int PRE_BITS      = 40,
  parameter int SOF_BITS      = 10,
  parameter int EOF_ZERO_BITS = 10,
  parameter int EOF_ONE_BITS  = 8,
  parameter int GUARD_BITS    = 24,
  localparam int LEN_W        = $clog2(MAX_BYTES + 1),
  localparam int ADDR_W       = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              bit_o,
  output logic              bit_valid_o,
  input  logic              bit_ready_i,
  output logic              busy_o,
  output logic              done_o
);

  localparam int CHAR_BITS = 10 + EGT_BITS;
  localparam int EOF_BITS  = 1 + EOF_ZERO_BITS + EOF_ONE_BITS;
  localparam int MAX_A     = (PRE_BITS > SOF_BITS) ? PRE_BITS : SOF_BITS;
  localparam int MAX_B     = (CHAR_BITS > EOF_BITS) ? CHAR_BITS : EOF_BITS;
  localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_PH    = (MAX_C > GUARD_BITS) ? MAX_C : GUARD_BITS;
  localparam int CNT_W     = (MAX_PH > 16) ? $clog2(MAX_PH) : 4;

  fbs_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             accept;

  assign active      = (phase != PH_IDLE);
  assign accept      = active && bit_ready_i;
  assign busy_o      = active;
  assign bit_valid_o = active;

  fbs_seq #(
    .MAX_BYTES (MAX_BYTES),
    .PRE_BITS  (PRE_BITS),
    .SOF_BITS  (SOF_BITS),
    .CHAR_BITS (CHAR_BITS),
    .EOF_BITS  (EOF_BITS),
    .GUARD_BITS(GUARD_BITS),
    .LEN_W     (LEN_W),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .len_i  (len_i),
    .adv_i  (accept),
    .phase_o(phase),
    .cnt_o  (cnt),
    .idx_o  (rd_addr_o),
    .done_o (done_o)
  );

  fbs_bit_gen #(
    .EOF_ZERO_BITS(EOF_ZERO_BITS),
    .CNT_W        (CNT_W)
  ) u_bit_gen (
    .phase_i(phase),
    .cnt_i  (cnt),
    .data_i (rd_data_i),
    .bit_o  (bit_o)
  );

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R7
  AST_NO_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !bit_ready_i) |=> busy_o); // R8

endmodule

// File: tb/frame_bit_serializer_tb.sv
module frame_bit_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 4;
  localparam int LW         = $clog2(NBYTES + 1);
  localparam int AW         = $clog2(NBYTES);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          bit_o, bit_valid, bit_ready, busy, done;
  logic [7:0]    mem [0:NBYTES-1];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic exp_bits [0:255];
  int exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data = mem[rd_addr];

  frame_bit_serializer #(.MAX_BYTES(NBYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .bit_o(bit_o), .bit_valid_o(bit_valid), .bit_ready_i(bit_ready),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R7 watchdog expired actual busy=%0d expected frame end", busy);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  // Expected frame per R2..R5 with default counts (40,10,start/8 data/stop/1 guard,1+10+8,24)
  task automatic build(input int n);
    exp_n = 0;
    for (int i = 0; i < 40; i++) push(1'b1);
    for (int i = 0; i < 10; i++) push(1'b0);
    for (int k = 0; k < n; k++) begin
      push(1'b0);
      for (int j = 0; j < 8; j++) push(mem[k][j]);
      push(1'b1);
      push(1'b1);
    end
    push(1'b1);
    for (int i = 0; i < 10; i++) push(1'b0);
    for (int i = 0; i < 8; i++) push(1'b1);
    for (int i = 0; i < 24; i++) push(1'b1);
  endtask

  function automatic logic ready_pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 3) != 0;
      2: return ((((c * 7) ^ (c >> 2)) >> 1) & 1) == 1;
      default: return (c % 16) >= 5;
    endcase
  endfunction

  task automatic run_frame(input int len, input int mode, input bit inject, input string tag);
    int eff, got, bad, hold_bad, c;
    logic prev_stall, prev_bit, saw_done;
    eff = (len > NBYTES) ? NBYTES : len;
    build(eff);
    got = 0; bad = 0; hold_bad = 0; c = 0;
    prev_stall = 1'b0; prev_bit = 1'b0; saw_done = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    len_i   = LW'(len);
    bit_ready = ready_pat(mode, 0);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    while (c < 3000) begin
      if (c > 0) @(negedge clk);
      bit_ready = ready_pat(mode, c);
      start_i   = inject && (c == 30 || c == 70);
      len_i     = inject ? LW'(1) : LW'(len);
      #1;
      if (done) begin
        saw_done = 1'b1;
        break;
      end
      if (prev_stall && !(bit_valid && bit_o == prev_bit)) hold_bad++;
      if (bit_valid && bit_ready) begin
        if (got < exp_n && bit_o != exp_bits[got]) begin
          if (bad == 0)
            $display("FAIL %s bit %0d actual %0d expected %0d", tag, got, bit_o, exp_bits[got]);
          bad++;
        end
        got++;
      end
      prev_stall = bit_valid && !bit_ready;
      prev_bit   = bit_o;
      c++;
    end
    start_i = 1'b0;
    chk(got == exp_n, {tag, " bit count"}, got, exp_n);
    chk(bad == 0, {tag, " bit content mismatches"}, bad, 0);
    chk(hold_bad == 0, "R6 stalled bit held", hold_bad, 0);
    chk(saw_done && !busy, "R7 done with busy low", {saw_done, busy}, 2);
    @(negedge clk);
    #1;
    chk(!done && !busy, "R7 done single cycle", {done, busy}, 0);
  endtask

  initial begin
    bit_ready = 1'b0;
    for (int i = 0; i < NBYTES; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!bit_valid, "R1 valid after reset", bit_valid, 0);
    chk(!done, "R1 done after reset", done, 0);
    rst_n = 1'b1;

    for (int len = 0; len <= NBYTES; len++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int i = 0; i < NBYTES; i++)
          mem[i] = 8'((len * 53 + mode * 29 + i * 91 + 7) ^ (i * 17));
        if (mode == 1) begin mem[0] = 8'h00; mem[1] = 8'hFF; mem[2] = 8'h01; mem[3] = 8'h80; end
        if (len == 0) run_frame(len, mode, 1'b0, "R5 empty frame R2 R4");
        else          run_frame(len, mode, 1'b0, "R3 byte framing R2 R4");
      end
    end

    mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h96; mem[3] = 8'h0F;
    run_frame(6, 1, 1'b0, "R9 oversize length");
    run_frame(3, 2, 1'b1, "R8 start while busy");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule